// File: doc/BRIEF.md
# Byte-Parallel Pseudo-Random Byte Source

This block produces one fresh pseudo-random byte per enabled clock for bit-error-rate test traffic. An 8-bit linear feedback register would normally move one bit per clock. This block instead computes eight of those single-bit moves within one cycle, through a chain of combinational step stages. Every step strobe therefore leaves a whole new byte on the parallel output, ready for a serializer or a comparator downstream.

A synchronous seed port loads a chosen starting value, so that a transmitter and a receiver can be placed in the same state. A receiver typically seeds with 0x01. An all-zero value would lock the register at zero forever, so a zero seed is replaced by 0x01. The output is the state register itself, so it is fully registered.

Top module: `prbs_byte_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state is set to 0x01, and `prbs_out` reads 0x01 after that edge.
- R2: A single step is defined as follows. Every bit i in 1..7 takes the old bit i-1. The new bit 0 is old bit 1 XOR bit 2 XOR bit 3 XOR bit 7.
- R3: When `seed_wr` is high and `seed_in` is nonzero, `prbs_out` equals `seed_in` after the edge.
- R4: When `seed_wr` and `step_en` are both high in the same cycle, the load wins and no advance takes place.
- R5: A load with `seed_in` = 0x00 leaves the state at 0x01.
- R6: When both `step_en` and `seed_wr` are low, `prbs_out` keeps its value.
- R7: When `step_en` is high and `seed_wr` is low, the state advances by exactly eight single steps (R2) in one clock. For the default configuration this gives, with s the old state: b7=s7^s3^s2^s1, b6=s6^s2^s1^s0, b5=s7^s5^s3^s2^s0, b4=s7^s6^s4^s3, b3=s6^s5^s3^s2, b2=s5^s4^s2^s1, b1=s4^s3^s1^s0, b0=s7^s1^s0.
- R8: `prbs_out` is never 0x00 once reset has been applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the state by one byte (eight single steps) |
| seed_wr | input | 1 | Load `seed_in` into the state |
| seed_in | input | 8 | Seed value; zero is replaced by 0x01 |
| prbs_out | output | 8 | Registered state, the current pseudo-random byte |

## Verification
A seed load and a byte advance can both be requested in the same cycle. The bench provokes this by raising `seed_wr` and `step_en` together, with a seed that differs from the byte the advance would have produced. It judges the result by requiring `prbs_out` to equal the seed, not the advanced value. Around this, every nonzero seed is loaded and advanced, and the result is compared against a bench model that runs eight single steps and also against the closed-form equations.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int unsigned PRBS_W = 8;
  // feedback mask: bits 7,3,2,1 feed the new bit 0
  localparam logic [PRBS_W-1:0] PRBS_TAPS = 8'h8E;
  localparam logic [PRBS_W-1:0] PRBS_SAFE_SEED = 8'h01;
  localparam int unsigned PRBS_STEPS = 8;
  typedef logic [PRBS_W-1:0] prbs_word_t;
endpackage

// File: rtl/prbs_one_step.sv
module prbs_one_step #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'h8E
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic fb;
  always_comb begin
    fb  = ^(cur & TAPS);
    nxt = {cur[W-2:0], fb};
  end
endmodule

// File: rtl/prbs_step_net.sv
module prbs_step_net #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'h8E,
  parameter int unsigned STEPS = 8
) (
  input  logic [W-1:0] state_q,
  output logic [W-1:0] state_adv
);
  logic [W-1:0] stage [STEPS+1];
  assign stage[0] = state_q;
  for (genvar k = 0; k < STEPS; k++) begin : g_chain
    prbs_one_step #(.W(W), .TAPS(TAPS)) u_step (
      .cur(stage[k]),
      .nxt(stage[k+1])
    );
  end
  assign state_adv = stage[STEPS];
endmodule

// File: rtl/prbs_seed_guard.sv
module prbs_seed_guard #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] SAFE = 8'h01
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] safe
);
  always_comb safe = (raw == '0) ? SAFE : raw;
endmodule

// File: rtl/prbs_byte_gen.sv
module prbs_byte_gen
  import prbs_pkg::*;
#(
  parameter int unsigned W = PRBS_W,
  parameter logic [W-1:0] TAPS = PRBS_TAPS,
  parameter int unsigned STEPS = PRBS_STEPS,
  parameter logic [W-1:0] SAFE = PRBS_SAFE_SEED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         seed_wr,
  input  logic [W-1:0] seed_in,
  output logic [W-1:0] prbs_out
);
  logic [W-1:0] state_q, state_adv, seed_ok;

  prbs_step_net #(.W(W), .TAPS(TAPS), .STEPS(STEPS)) u_net (
    .state_q(state_q),
    .state_adv(state_adv)
  );

  prbs_seed_guard #(.W(W), .SAFE(SAFE)) u_guard (
    .raw(seed_in),
    .safe(seed_ok)
  );

  // load has priority over advance (R4)
  always_ff @(posedge clk) begin
    if (rst)          state_q <= SAFE;
    else if (seed_wr) state_q <= seed_ok;
    else if (step_en) state_q <= state_adv;
  end

  assign prbs_out = state_q;

  p_reset_r1: assert property (@(posedge clk) rst |=> prbs_out == SAFE);
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (seed_wr && seed_in != '0) |=> prbs_out == $past(seed_in));
  p_prio_r4: assert property (@(posedge clk) disable iff (rst)
    (seed_wr && step_en && seed_in != '0) |=> prbs_out == $past(seed_in));
  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (seed_wr && seed_in == '0) |=> prbs_out == SAFE);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!seed_wr && !step_en) |=> $stable(prbs_out));
  p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> prbs_out != '0);

  if (W == 8 && STEPS == 8 && TAPS == 8'h8E) begin : g_cf_chk
    logic [7:0] cf;
    always_comb begin
      cf[7] = state_q[7]^state_q[3]^state_q[2]^state_q[1];
      cf[6] = state_q[6]^state_q[2]^state_q[1]^state_q[0];
      cf[5] = state_q[7]^state_q[5]^state_q[3]^state_q[2]^state_q[0];
      cf[4] = state_q[7]^state_q[6]^state_q[4]^state_q[3];
      cf[3] = state_q[6]^state_q[5]^state_q[3]^state_q[2];
      cf[2] = state_q[5]^state_q[4]^state_q[2]^state_q[1];
      cf[1] = state_q[4]^state_q[3]^state_q[1]^state_q[0];
      cf[0] = state_q[7]^state_q[1]^state_q[0];
    end
    p_closed_form_r7: assert property (@(posedge clk) disable iff (rst)
      (step_en && !seed_wr) |=> prbs_out == $past(cf));
  end
endmodule

// File: tb/prbs_byte_gen_tb.sv
module prbs_byte_gen_tb;
  localparam time CLK_PERIOD = 10ns;
  logic clk = 1'b0;
  logic rst, step_en, seed_wr;
  logic [7:0] seed_in, prbs_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_byte_gen u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_wr(seed_wr),
    .seed_in(seed_in), .prbs_out(prbs_out)
  );

  function automatic logic [7:0] one_step(input logic [7:0] s); // R2
    return {s[6:0], s[1]^s[2]^s[3]^s[7]};
  endfunction
  function automatic logic [7:0] eight_steps(input logic [7:0] s);
    logic [7:0] t = s;
    for (int i = 0; i < 8; i++) t = one_step(t);
    return t;
  endfunction
  function automatic logic [7:0] closed(input logic [7:0] s);
    return {s[7]^s[3]^s[2]^s[1], s[6]^s[2]^s[1]^s[0],
            s[7]^s[5]^s[3]^s[2]^s[0], s[7]^s[6]^s[4]^s[3],
            s[6]^s[5]^s[3]^s[2], s[5]^s[4]^s[2]^s[1],
            s[4]^s[3]^s[1]^s[0], s[7]^s[1]^s[0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic r, input logic st, input logic wr, input logic [7:0] d);
    rst = r; step_en = st; seed_wr = wr; seed_in = d;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp;
    drive(1, 1, 1, 8'h5A);
    tick; tick;
    chk("R1 reset", prbs_out, 8'h01);
    drive(0, 0, 0, 8'h00);
    tick;
    chk("R6 hold after reset", prbs_out, 8'h01);
    for (int s = 1; s < 256; s++) begin
      drive(0, 0, 1, s[7:0]);
      tick;
      chk("R3 load", prbs_out, s[7:0]);
      exp = eight_steps(s[7:0]);
      chk("R7 closed form vs model", closed(s[7:0]), exp);
      drive(0, 1, 0, 8'h00);
      tick;
      chk("R7 advance", prbs_out, exp);
      chk("R8 nonzero", {7'd0, prbs_out == 8'h00}, 8'h00);
      drive(0, 0, 0, ~s[7:0]);
      tick; tick;
      chk("R6 hold", prbs_out, exp);
    end
    // free run from a seed: many consecutive advances
    drive(0, 0, 1, 8'hC3); tick;
    exp = 8'hC3;
    for (int i = 0; i < 300; i++) begin
      drive(0, 1, 0, 8'h00); tick;
      exp = eight_steps(exp);
      chk("R7 run", prbs_out, exp);
    end
    // load and step together: load must win
    for (int s = 1; s < 256; s += 17) begin
      drive(0, 1, 1, s[7:0]); tick;
      chk("R4 priority", prbs_out, s[7:0]);
    end
    drive(0, 0, 1, 8'h77); tick;
    drive(0, 1, 1, 8'h00); tick;
    chk("R4 R5 zero seed with step", prbs_out, 8'h01);
    drive(0, 0, 1, 8'h99); tick;
    drive(0, 0, 1, 8'h00); tick;
    chk("R5 zero seed", prbs_out, 8'h01);
    drive(0, 1, 0, 8'h00); tick;
    chk("R7 advance from safe seed", prbs_out, eight_steps(8'h01));
    drive(1, 1, 1, 8'hAA); tick;
    chk("R1 reset mid run", prbs_out, 8'h01);
    drive(0, 0, 0, 8'h00); tick;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule